// File: doc/BRIEF.md
# I2C Target Memory Access Engine

This block is a two-wire bus target with a 7-bit device address. It gives byte-wide read and write access to a 256-location register space. SCL and SDA are synchronised into the system clock domain. START, repeated START and STOP are recovered from the synchronised lines. Bytes are shifted most significant bit first, and the block answers each byte with an acknowledge or a not-acknowledge on the ninth clock.

The open-drain SDA driver is modelled as one enable output: 1 pulls the line low. The engine never touches SCL. An internal address pointer selects the location being accessed. Memory and register blocks are reached through single-cycle read and write strobes with a combinational read-data return.

The block has two address-advance rules:
- Write bursts stay within an aligned eight-location row.
- Read bursts run straight through the space and roll from FFh back to 00h.

While the nonvolatile commit logic reports busy, the device address byte is not acknowledged. A host can therefore poll for completion by addressing the block repeatedly.

Top module: `i2c_mem_target`

## Requirements
- R1: The block acknowledges (drives SDA low on the ninth clock) only an address byte whose upper seven bits are 101000 followed by the value of `addr_sel_i`. Bit 0 of that byte selects the direction: 0 for write, 1 for read. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R2: An address byte that arrives while `nv_busy_i` is high is not acknowledged, even when it matches.
- R3: In a write transfer, the byte after the address byte loads the address pointer, and every byte is acknowledged. Each later byte produces exactly one `reg_wr_o` pulse carrying the pointer value and that byte.
- R4: After each data byte of a write, the pointer advances only in its low three bits, wrapping within its row. For example, three bytes written from 06h land at 06h, 07h and 00h.
- R5: A read transfer starts at the current pointer value. A write transfer holding only the pointer byte, followed by a repeated START, positions the pointer for the read.
- R6: During reads the pointer increments by one per byte with no row wrap, and it rolls over from FFh to 00h.
- R7: A master acknowledge after a read byte makes the block send the next byte. A master not-acknowledge makes it release SDA and drive nothing further.
- R8: Locations 40h to EFh are reserved. Reads from them return 00h. Writes to them are acknowledged but produce no `reg_wr_o` pulse.
- R9: SDA is sampled on SCL rising edges. The SDA enable changes only while SCL is low, following an SCL falling edge.
- R10: A STOP in the middle of a byte aborts the transfer. No write is issued, and later bus bits are ignored until the next START.
- R11: After reset, SDA is released and neither strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel_i | input | 1 | Selects the lowest bit of the device address |
| nv_busy_i | input | 1 | High while a nonvolatile commit is in progress |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_addr_o | output | 8 | Current address pointer, valid with either strobe |
| reg_rd_o | output | 1 | Single-cycle read strobe |
| reg_rdata_i | input | 8 | Read data, combinational from `reg_addr_o` |
| reg_wr_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | 8 | Write data, valid with `reg_wr_o` |

## Verification
Every result is tied to an SCL falling edge. That edge reaches the engine through the synchroniser and the edge register, a few system clocks later. The write and read strobes fire in that detection cycle, and the SDA enable changes one clock after it.

The bench holds each SCL phase for a quarter period much longer than this latency. It reads acknowledges and read data in the middle of the SCL high phase. It samples the strobes and the enable on the falling system-clock edge, so each result is observed well after it settles and well before the next bus event.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int ADDR_W    = 8;
  localparam int BYTE_W    = 8;
  localparam int PAGE_BITS = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_MADDR,
    ST_MADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;

  // write bursts stay inside the aligned row: only the low bits advance
  function automatic logic [ADDR_W-1:0] row_next(input logic [ADDR_W-1:0] a);
    logic [PAGE_BITS-1:0] low;
    low = a[PAGE_BITS-1:0] + {{(PAGE_BITS-1){1'b0}}, 1'b1};
    return {a[ADDR_W-1:PAGE_BITS], low};
  endfunction

  // read bursts walk the whole space and roll over at the top
  function automatic logic [ADDR_W-1:0] lin_next(input logic [ADDR_W-1:0] a);
    return a + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;
  logic              sda_s;

  assign scl_s = scl_sh[STAGES-1];
  assign sda_s = sda_sh[STAGES-1];

  // idle bus is high: reset the chain to ones so no false START is seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         rise_i,
  input  logic         sda_i,
  input  logic         tx_load_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         tx_shift_i,
  output logic [W-1:0] rx_byte_o,
  output logic         full_o,
  output logic         tx_peek_o
);

  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rx_q;
  logic [W-1:0]  tx_q;

  assign full_o    = (cnt_q == CW'(W));
  assign rx_byte_o = rx_q;
  assign tx_peek_o = tx_q[W-2];

  // the counter saturates at W, so the ninth clock does not disturb the byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (rise_i && !full_o) begin
      cnt_q <= cnt_q + CW'(1);
      rx_q  <= {rx_q[W-2:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tx_q <= '0;
    else if (tx_load_i)  tx_q <= tx_data_i;
    else if (tx_shift_i) tx_q <= {tx_q[W-2:0], 1'b0};
  end

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [5:0]        DEV_ADDR_HI = 6'b101000,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] RSV_LO      = 8'h40,
  parameter logic [ADDR_W-1:0] RSV_HI      = 8'hEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  input  logic              nv_busy_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_rd_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              reg_wr_o,
  output logic [BYTE_W-1:0] reg_wdata_o
);

  tgt_state_e        state_q;
  logic              rw_q;
  logic              mack_q;
  logic              oe_q;
  logic [ADDR_W-1:0] addr_q;

  // events recovered from the bus
  logic              sda_s_w;
  logic              scl_rise_w;
  logic              scl_fall_w;
  logic              start_w;
  logic              stop_w;

  // shifter interface
  logic              cnt_clr_w;
  logic [BYTE_W-1:0] rx_byte_w;
  logic              byte_full_w;
  logic              tx_peek_w;
  logic              tx_shift_w;
  logic [BYTE_W-1:0] tx_data_w;

  // named internal events, also used by the checker
  logic              byte_done_w;
  logic              dev_byte_done_w;
  logic              dev_match_w;
  logic              in_ack_w;
  logic              rd_fetch_w;
  logic              wr_fire_w;
  logic              rsv_w;

  i2c_line_cond #(.STAGES(SYNC_STAGES)) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s_w),
    .scl_rise_o (scl_rise_w),
    .scl_fall_o (scl_fall_w),
    .start_o    (start_w),
    .stop_o     (stop_w)
  );

  i2c_bit_engine #(.W(BYTE_W)) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (cnt_clr_w),
    .rise_i     (scl_rise_w),
    .sda_i      (sda_s_w),
    .tx_load_i  (rd_fetch_w),
    .tx_data_i  (tx_data_w),
    .tx_shift_i (tx_shift_w),
    .rx_byte_o  (rx_byte_w),
    .full_o     (byte_full_w),
    .tx_peek_o  (tx_peek_w)
  );

  assign in_ack_w = (state_q == ST_DEV_ACK) || (state_q == ST_MADDR_ACK) ||
                    (state_q == ST_WDATA_ACK) || (state_q == ST_RACK);

  assign byte_done_w     = byte_full_w && scl_fall_w;
  assign dev_byte_done_w = (state_q == ST_DEV) && byte_done_w;
  assign dev_match_w     = (rx_byte_w[BYTE_W-1:1] == {DEV_ADDR_HI, addr_sel_i});
  assign rsv_w           = in_window(addr_q, RSV_LO, RSV_HI);

  assign rd_fetch_w = scl_fall_w &&
                      (((state_q == ST_DEV_ACK) && rw_q) ||
                       ((state_q == ST_RACK) && mack_q));
  assign wr_fire_w  = (state_q == ST_WDATA) && byte_done_w;
  assign tx_shift_w = (state_q == ST_RDATA) && scl_fall_w && !byte_full_w;
  assign cnt_clr_w  = start_w || (scl_fall_w && in_ack_w);
  assign tx_data_w  = rsv_w ? '0 : reg_rdata_i;

  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = rx_byte_w;
  assign reg_wr_o    = wr_fire_w && !rsv_w;
  assign reg_rd_o    = rd_fetch_w && !rsv_w;
  assign sda_oe_o    = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      addr_q  <= '0;
    end else if (start_w) begin
      state_q <= ST_DEV;
      oe_q    <= 1'b0;
    end else if (stop_w) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: ;
        ST_DEV: begin
          if (byte_done_w) begin
            if (dev_match_w && !nv_busy_i) begin
              oe_q    <= 1'b1;
              rw_q    <= rx_byte_w[0];
              state_q <= ST_DEV_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall_w) begin
            if (rw_q) begin
              oe_q    <= ~tx_data_w[BYTE_W-1];
              addr_q  <= lin_next(addr_q);
              state_q <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_MADDR;
            end
          end
        end
        ST_MADDR: begin
          if (byte_done_w) begin
            oe_q    <= 1'b1;
            addr_q  <= rx_byte_w;
            state_q <= ST_MADDR_ACK;
          end
        end
        ST_MADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall_w) begin
            oe_q    <= 1'b0;
            state_q <= ST_WDATA;
          end
        end
        ST_WDATA: begin
          if (byte_done_w) begin
            oe_q    <= 1'b1;
            addr_q  <= row_next(addr_q);
            state_q <= ST_WDATA_ACK;
          end
        end
        ST_RDATA: begin
          if (scl_fall_w) begin
            if (byte_full_w) begin
              oe_q    <= 1'b0;
              state_q <= ST_RACK;
            end else begin
              oe_q <= ~tx_peek_w;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_w) mack_q <= ~sda_s_w;
          if (scl_fall_w) begin
            if (mack_q) begin
              oe_q    <= ~tx_data_w[BYTE_W-1];
              addr_q  <= lin_next(addr_q);
              state_q <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RSV_LO = 8'h40,
  parameter logic [ADDR_W-1:0] RSV_HI = 8'hEF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_fall_w,
  input logic              stop_w,
  input logic              dev_byte_done_w,
  input logic              dev_match_w,
  input logic              nv_busy_i,
  input logic              sda_oe_o,
  input logic              reg_wr_o,
  input logic              reg_rd_o,
  input logic [ADDR_W-1:0] reg_addr_o
);

  p_addr_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_byte_done_w && dev_match_w && !nv_busy_i) |=> sda_oe_o);

  p_busy_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_byte_done_w && nv_busy_i) |=> !sda_oe_o);

  p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);

  p_row_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> (reg_addr_o[ADDR_W-1:PAGE_BITS] == $past(reg_addr_o[ADDR_W-1:PAGE_BITS])) &&
                 (reg_addr_o[PAGE_BITS-1:0] == $past(reg_addr_o[PAGE_BITS-1:0]) + 3'd1));

  p_rd_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |=> (reg_addr_o == $past(reg_addr_o) + 8'd1));

  p_rsv_no_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> !((reg_addr_o >= RSV_LO) && (reg_addr_o <= RSV_HI)));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && reg_rd_o));

  p_drive_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_fall_w));

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> !sda_oe_o);

endmodule

bind i2c_mem_target i2c_mem_target_chk #(.RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .scl_fall_w      (scl_fall_w),
  .stop_w          (stop_w),
  .dev_byte_done_w (dev_byte_done_w),
  .dev_match_w     (dev_match_w),
  .nv_busy_i       (nv_busy_i),
  .sda_oe_o        (sda_oe_o),
  .reg_wr_o        (reg_wr_o),
  .reg_rd_o        (reg_rd_o),
  .reg_addr_o      (reg_addr_o)
);

// File: tb/i2c_mem_target_tb.sv
module i2c_mem_target_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 8;
  localparam int WD_CYCLES  = 150000;

  typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic nv_busy = 1'b0;

  logic       sda_oe;
  logic [7:0] reg_addr;
  logic       reg_rd;
  logic [7:0] reg_rdata;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  wire        sda_line = sda_m & ~sda_oe;

  logic [7:0] mem     [256];
  logic [7:0] exp_mem [256];
  logic [7:0] wbuf    [8];
  wr_item_t   wq[$];
  int         n_checks = 0;
  int         n_errs = 0;
  int         hi_changes = 0;
  logic       oe_last = 1'b0;
  logic       done = 1'b0;
  logic [7:0] cur_addr = 8'h00;
  logic       devx = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mem_target dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .addr_sel_i  (addr_sel),
    .nv_busy_i   (nv_busy),
    .sda_oe_o    (sda_oe),
    .reg_addr_o  (reg_addr),
    .reg_rd_o    (reg_rd),
    .reg_rdata_i (reg_rdata),
    .reg_wr_o    (reg_wr),
    .reg_wdata_o (reg_wdata)
  );

  function automatic logic [7:0] pattern(input int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  function automatic logic reserved(input logic [7:0] a);
    return (a > 8'h3F) && (a < 8'hF0);
  endfunction

  // target-side memory model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pattern(i);
    end else if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = mem[reg_addr];

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected writes as strobes appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr) begin
        if (wq.size() == 0) begin
          n_checks++;
          n_errs++;
          $display("FAIL R8/R10 unexpected write: actual=%h@%h expected=none", reg_wdata, reg_addr);
        end else begin
          wr_item_t w;
          w = wq.pop_front();
          check8("R3 write address", reg_addr, w.a);
          check8("R3 write data", reg_wdata, w.d);
        end
      end
      if (sda_oe !== oe_last && scl_m) hi_changes++;
      oe_last = sda_oe;
    end
  end

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    sda_m = b;    qwait();
    scl_m = 1'b1; qwait();
    r = sda_line; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
    bit_xfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic more, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, r);
      b[i] = r;
    end
    bit_xfer(~more, r);
  endtask

  task automatic do_write(input logic [7:0] start, input int n);
    logic ack;
    logic [7:0] a;
    bus_start();
    send_byte({6'b101000, devx, 1'b0}, ack);
    check8("R1 address ack (write)", {7'd0, ack}, 8'd1);
    send_byte(start, ack);
    check8("R3 pointer byte ack", {7'd0, ack}, 8'd1);
    for (int i = 0; i < n; i++) begin
      a = {start[7:3], start[2:0] + 3'(i)};
      if (!reserved(a)) begin
        wq.push_back({a, wbuf[i]});
        exp_mem[a] = wbuf[i];
      end
      send_byte(wbuf[i], ack);
      check8("R3/R8 data byte ack", {7'd0, ack}, 8'd1);
    end
    cur_addr = {start[7:3], start[2:0] + 3'(n)};
    bus_stop();
  endtask

  task automatic do_read(input logic dummy, input logic [7:0] start, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    logic [7:0] e;
    bus_start();
    if (dummy) begin
      send_byte({6'b101000, devx, 1'b0}, ack);
      check8("R5 dummy write address ack", {7'd0, ack}, 8'd1);
      send_byte(start, ack);
      check8("R5 dummy pointer ack", {7'd0, ack}, 8'd1);
      cur_addr = start;
      bus_start();
    end
    send_byte({6'b101000, devx, 1'b1}, ack);
    check8("R1 address ack (read)", {7'd0, ack}, 8'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      e = reserved(cur_addr) ? 8'h00 : exp_mem[cur_addr];
      check8(tag, b, e);
      cur_addr = cur_addr + 8'd1;
    end
    check8("R7 SDA released after master NACK", {7'd0, sda_oe}, 8'd0);
    bus_stop();
  endtask

  initial begin
    logic ack;
    logic r;
    for (int i = 0; i < 256; i++) exp_mem[i] = pattern(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    check8("R11 SDA released", {7'd0, sda_oe}, 8'd0);
    check8("R11 no write strobe", {7'd0, reg_wr}, 8'd0);
    check8("R11 no read strobe", {7'd0, reg_rd}, 8'd0);

    // R1 R3 basic write and read back
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2;
    do_write(8'h10, 2);
    do_read(1'b1, 8'h10, 2, "R5 read after dummy write");

    // R1 wrong address low bit is ignored
    bus_start();
    send_byte({7'b1010001, 1'b0}, ack);
    check8("R1 wrong address not acked", {7'd0, ack}, 8'd0);
    bus_stop();

    // R1 select pin moves the address
    addr_sel = 1'b1; devx = 1'b1;
    wbuf[0] = 8'hC3;
    do_write(8'h30, 1);
    do_read(1'b1, 8'h30, 1, "R1 read with select pin high");
    addr_sel = 1'b0; devx = 1'b0;

    // R4 row wrap: 06h, 07h, then 00h
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(8'h06, 3);
    // R6 reads cross the row boundary
    do_read(1'b1, 8'h06, 3, "R6 read crosses row");
    // R6 roll over FFh -> 00h
    do_read(1'b1, 8'hFE, 3, "R6 read rolls over");
    // R5 read from the current pointer without a dummy write
    do_read(1'b0, 8'h00, 2, "R5 read at current pointer");

    // R8 reserved range
    wbuf[0] = 8'h77; wbuf[1] = 8'h88;
    do_write(8'h45, 2);
    do_read(1'b1, 8'hEE, 3, "R8 reserved reads zero");
    do_read(1'b1, 8'h45, 1, "R8 reserved write ignored");

    // R2 busy refuses the address, then acknowledge polling succeeds
    nv_busy = 1'b1;
    bus_start();
    send_byte({6'b101000, 1'b0, 1'b0}, ack);
    check8("R2 busy address not acked", {7'd0, ack}, 8'd0);
    bus_stop();
    nv_busy = 1'b0;
    wbuf[0] = 8'h5A;
    do_write(8'h20, 1);

    // R10 STOP inside a data byte aborts the write
    bus_start();
    send_byte({6'b101000, 1'b0, 1'b0}, ack);
    check8("R10 address ack", {7'd0, ack}, 8'd1);
    send_byte(8'h28, ack);
    check8("R10 pointer ack", {7'd0, ack}, 8'd1);
    for (int i = 0; i < 4; i++) bit_xfer(1'b1, r);
    bus_stop();
    scl_m = 1'b0; qwait();
    send_byte(8'hA0, ack);
    check8("R10 bits after abort ignored", {7'd0, ack}, 8'd0);
    bus_stop();
    do_read(1'b1, 8'h28, 1, "R10 aborted location unchanged");

    check8("R3 all expected writes seen", 8'(wq.size()), 8'd0);
    check8("R9 SDA changes only while SCL low", 8'(hi_changes), 8'd0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

endmodule